// File: doc/BRIEF.md
# Configurable Address Translation Buffer

This block holds recently used translations from virtual page numbers to physical page numbers. Three build-time parameters shape it: the total number of entries, the number of ways per set, and the width of the stored physical page number. With the way count equal to the entry count it is one fully associative set, for example 10 entries. With fewer ways it is a set-associative array, for example 512 entries in 128 sets of 4 ways. The same source serves both shapes.

A lookup request carries a 32-bit address and a cycle stamp. One cycle after it is accepted, a response gives the stored page number or the miss code. A write request carries a page number, an address and a cycle stamp. It updates a matching entry, fills a free way, or evicts the way whose stamp is oldest. A valid entry whose stamp is zero is pinned and is never evicted. A write that finds only pinned ways in its set is dropped and reported. A combinational debug port reads any single entry, so the whole contents can be inspected.

Both request ports use valid/ready. Ready is low during reset and high at all other times, so a request is accepted on every clock edge where valid and ready are both high. Responses and the reject pulse cannot be held back. Each is present for exactly one cycle, and the consumer must take it in that cycle.

Top module: `xlat_buffer`

## Requirements
- R1: During reset, no response or reject is produced and both ready outputs are low. After reset every entry reads back as invalid.
- R2: The page number is taken from address bits 31:16. The set is the page number modulo the set count (ENTRIES/WAYS), and the tag is the page number divided by the set count. A fully associative build has one set, and the whole page number is its tag.
- R3: An accepted lookup that matches a valid entry's tag in its set gives rsp_valid=1 and rsp_hit=1 on the following cycle. rsp_data then carries the stored page number, zero-extended to 32 bits, and the entry's stamp becomes the request's stamp.
- R4: An accepted lookup with no match gives rsp_valid=1, rsp_hit=0 and rsp_data=32'hFFFFFFFF on the following cycle. No entry changes.
- R5: A write whose tag matches a valid entry in its set replaces that entry's data and sets its stamp to the write's stamp.
- R6: A write with no tag match fills the lowest-numbered invalid way of its set with the valid bit, tag, data and stamp.
- R7: When a write has no match and no free way, it replaces the valid way with the smallest nonzero stamp. On a tie, the lowest-numbered way is replaced.
- R8: A valid entry with stamp 0 is never evicted. If every way of the set is pinned, the write changes nothing and wr_reject is high for exactly the following cycle.
- R9: When a write and a lookup are accepted in the same cycle, the write applies first. The lookup result and its stamp update see the state after the write.
- R10: The debug port returns, in the same cycle, the valid bit, tag, stamp and data of entry dbg_idx, where the entry number is set*WAYS+way.
- R11: Ready is high in every cycle after reset. rsp_valid is high in exactly those cycles that follow an accepted lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready |
| lk_addr | input | 32 | Lookup virtual address |
| lk_stamp | input | STAMP_W | Cycle stamp for the lookup |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_data | output | 32 | Page number on a hit, all ones on a miss |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request ready |
| wr_addr | input | 32 | Write virtual address |
| wr_stamp | input | STAMP_W | Cycle stamp for the write |
| wr_data | input | DATA_W | Physical page number to store |
| wr_reject | output | 1 | Write dropped because every way of its set was pinned |
| dbg_idx | input | EIDX_W | Entry number to read back |
| dbg_valid | output | 1 | Valid bit of the selected entry |
| dbg_tag | output | 16 | Tag of the selected entry |
| dbg_stamp | output | STAMP_W | Stamp of the selected entry |
| dbg_data | output | DATA_W | Data of the selected entry |

## Verification
A lookup and a write can be accepted in the same cycle. When they fall in the same set, the write may create, overwrite or evict the very entry the lookup is after. The bench draws both addresses from a small shared pool of page numbers confined to two sets, so that such collisions happen often. It also mixes in zero stamps and repeated stamps, so that pinned entries and victim ties occur. A behavioural model applies the write and then the lookup on every edge. Responses, rejects and a rotating debug read are compared against that model every cycle, for a fully associative build and for a 4-way build.

// File: rtl/xb_pkg.sv
package xb_pkg;
  localparam int XB_ADDR_W = 32;
  localparam int XB_OFS_W  = 16;
  localparam logic [31:0] XB_MISS = 32'hFFFF_FFFF;

  function automatic int xb_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xb_split.sv
module xb_split #(
  parameter int SETS  = 1,
  parameter int IDX_W = 1,
  parameter int VPN_W = 16
) (
  input  logic [xb_pkg::XB_ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]             set_o,
  output logic [VPN_W-1:0]             tag_o
);
  logic [VPN_W-1:0] vpn;
  logic unused_ofs;

  assign vpn        = addr[xb_pkg::XB_ADDR_W-1:xb_pkg::XB_OFS_W];
  assign unused_ofs = ^addr[xb_pkg::XB_OFS_W-1:0];
  assign set_o      = IDX_W'(vpn % VPN_W'(SETS));
  assign tag_o      = vpn / VPN_W'(SETS);
endmodule

// File: rtl/xb_way_search.sv
module xb_way_search #(
  parameter int WAYS    = 4,
  parameter int WAY_W   = 2,
  parameter int VPN_W   = 16,
  parameter int STAMP_W = 32
) (
  input  logic               v   [WAYS],
  input  logic [VPN_W-1:0]   t   [WAYS],
  input  logic [STAMP_W-1:0] s   [WAYS],
  input  logic [VPN_W-1:0]   key,
  output logic               hit,
  output logic [WAY_W-1:0]   hit_way,
  output logic               free_ok,
  output logic [WAY_W-1:0]   free_way,
  output logic               vic_ok,
  output logic [WAY_W-1:0]   vic_way
);
  logic [STAMP_W-1:0] best;

  always_comb begin
    hit = 1'b0; hit_way = '0;
    free_ok = 1'b0; free_way = '0;
    vic_ok = 1'b0; vic_way = '0; best = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (v[w] && t[w] == key && !hit) begin
        hit = 1'b1; hit_way = WAY_W'(w);
      end
      if (!v[w] && !free_ok) begin
        free_ok = 1'b1; free_way = WAY_W'(w);
      end
      if (v[w] && s[w] != '0 && (!vic_ok || s[w] < best)) begin
        vic_ok = 1'b1; vic_way = WAY_W'(w); best = s[w];
      end
    end
  end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
  parameter int ENTRIES = 10,
  parameter int WAYS    = 10,
  parameter int DATA_W  = 16,
  parameter int STAMP_W = 32,
  localparam int SETS   = ENTRIES / WAYS,
  localparam int VPN_W  = xb_pkg::XB_ADDR_W - xb_pkg::XB_OFS_W,
  localparam int IDX_W  = xb_pkg::xb_bits(SETS),
  localparam int WAY_W  = xb_pkg::xb_bits(WAYS),
  localparam int EIDX_W = xb_pkg::xb_bits(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lk_valid,
  output logic                          lk_ready,
  input  logic [xb_pkg::XB_ADDR_W-1:0]  lk_addr,
  input  logic [STAMP_W-1:0]            lk_stamp,
  output logic                          rsp_valid,
  output logic                          rsp_hit,
  output logic [31:0]                   rsp_data,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [xb_pkg::XB_ADDR_W-1:0]  wr_addr,
  input  logic [STAMP_W-1:0]            wr_stamp,
  input  logic [DATA_W-1:0]             wr_data,
  output logic                          wr_reject,
  input  logic [EIDX_W-1:0]             dbg_idx,
  output logic                          dbg_valid,
  output logic [VPN_W-1:0]              dbg_tag,
  output logic [STAMP_W-1:0]            dbg_stamp,
  output logic [DATA_W-1:0]             dbg_data
);
  // stored state
  logic               val_q [ENTRIES];
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [STAMP_W-1:0] stp_q [ENTRIES];
  logic [DATA_W-1:0]  dat_q [ENTRIES];
  // state after the write stage
  logic               val_m [ENTRIES];
  logic [VPN_W-1:0]   tag_m [ENTRIES];
  logic [STAMP_W-1:0] stp_m [ENTRIES];
  logic [DATA_W-1:0]  dat_m [ENTRIES];
  // stamps after the lookup stage
  logic [STAMP_W-1:0] stp_n [ENTRIES];

  logic ready_q, lk_fire, wr_fire, wr_take, wr_drop;
  logic [IDX_W-1:0] w_set, l_set;
  logic [VPN_W-1:0] w_tag, l_tag;

  assign lk_ready = ready_q;
  assign wr_ready = ready_q;
  assign lk_fire  = lk_valid && ready_q;
  assign wr_fire  = wr_valid && ready_q;

  xb_split #(.SETS(SETS), .IDX_W(IDX_W), .VPN_W(VPN_W)) u_wsplit (
    .addr(wr_addr), .set_o(w_set), .tag_o(w_tag));
  xb_split #(.SETS(SETS), .IDX_W(IDX_W), .VPN_W(VPN_W)) u_lsplit (
    .addr(lk_addr), .set_o(l_set), .tag_o(l_tag));

  // write-side search over the stored set
  logic               wv [WAYS];
  logic [VPN_W-1:0]   wt [WAYS];
  logic [STAMP_W-1:0] ws [WAYS];
  logic w_hit, w_free, w_vic;
  logic [WAY_W-1:0] w_hitway, w_freeway, w_vicway;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      wv[w] = val_q[int'(w_set) * WAYS + w];
      wt[w] = tag_q[int'(w_set) * WAYS + w];
      ws[w] = stp_q[int'(w_set) * WAYS + w];
    end
  end

  xb_way_search #(.WAYS(WAYS), .WAY_W(WAY_W), .VPN_W(VPN_W), .STAMP_W(STAMP_W)) u_wsearch (
    .v(wv), .t(wt), .s(ws), .key(w_tag),
    .hit(w_hit), .hit_way(w_hitway), .free_ok(w_free), .free_way(w_freeway),
    .vic_ok(w_vic), .vic_way(w_vicway));

  always_comb begin
    int we;
    logic [WAY_W-1:0] pick;
    val_m = val_q; tag_m = tag_q; stp_m = stp_q; dat_m = dat_q;
    wr_take = 1'b0; wr_drop = 1'b0; pick = '0;
    if (wr_fire) begin
      if (w_hit)       begin wr_take = 1'b1; pick = w_hitway;  end
      else if (w_free) begin wr_take = 1'b1; pick = w_freeway; end
      else if (w_vic)  begin wr_take = 1'b1; pick = w_vicway;  end
      else             wr_drop = 1'b1;
    end
    we = int'(w_set) * WAYS + int'(pick);
    if (wr_take) begin
      val_m[we] = 1'b1;
      tag_m[we] = w_tag;
      stp_m[we] = wr_stamp;
      dat_m[we] = wr_data;
    end
  end

  // lookup-side search over the post-write set
  logic               lv [WAYS];
  logic [VPN_W-1:0]   lt [WAYS];
  logic [STAMP_W-1:0] ls [WAYS];
  logic l_hit, l_free, l_vic;
  logic [WAY_W-1:0] l_hitway, l_freeway, l_vicway;
  logic [31:0] l_data;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lv[w] = val_m[int'(l_set) * WAYS + w];
      lt[w] = tag_m[int'(l_set) * WAYS + w];
      ls[w] = stp_m[int'(l_set) * WAYS + w];
    end
  end

  xb_way_search #(.WAYS(WAYS), .WAY_W(WAY_W), .VPN_W(VPN_W), .STAMP_W(STAMP_W)) u_lsearch (
    .v(lv), .t(lt), .s(ls), .key(l_tag),
    .hit(l_hit), .hit_way(l_hitway), .free_ok(l_free), .free_way(l_freeway),
    .vic_ok(l_vic), .vic_way(l_vicway));

  logic unused_lside;
  assign unused_lside = l_free ^ l_vic ^ (^l_freeway) ^ (^l_vicway);

  always_comb begin
    int le;
    le     = int'(l_set) * WAYS + int'(l_hitway);
    stp_n  = stp_m;
    l_data = 32'(dat_m[le]);
    if (lk_fire && l_hit) stp_n[le] = lk_stamp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        val_q[e] <= 1'b0; tag_q[e] <= '0; stp_q[e] <= '0; dat_q[e] <= '0;
      end
      ready_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= xb_pkg::XB_MISS;
      wr_reject <= 1'b0;
    end else begin
      val_q     <= val_m;
      tag_q     <= tag_m;
      stp_q     <= stp_n;
      dat_q     <= dat_m;
      ready_q   <= 1'b1;
      rsp_valid <= lk_fire;
      rsp_hit   <= lk_fire && l_hit;
      rsp_data  <= (lk_fire && l_hit) ? l_data : xb_pkg::XB_MISS;
      wr_reject <= wr_drop;
    end
  end

  always_comb begin
    dbg_valid = 1'b0; dbg_tag = '0; dbg_stamp = '0; dbg_data = '0;
    if (int'(dbg_idx) < ENTRIES) begin
      dbg_valid = val_q[dbg_idx];
      dbg_tag   = tag_q[dbg_idx];
      dbg_stamp = stp_q[dbg_idx];
      dbg_data  = dat_q[dbg_idx];
    end
  end
endmodule

// File: rtl/xb_chk.sv
module xb_chk #(
  parameter int DATA_W = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic        lk_ready,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [31:0] rsp_data,
  input logic        wr_reject
);
  p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);
  p_no_stray_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready) |=> !rsp_valid);
  p_ready_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ready |=> (lk_ready && wr_ready));
  p_miss_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_data == 32'hFFFF_FFFF);
  p_hit_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (64'(rsp_data) >> DATA_W) == 64'd0);
  p_hit_needs_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  p_reject_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> $past(wr_valid && wr_ready));
endmodule

bind xlat_buffer xb_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_data(rsp_data), .wr_reject(wr_reject));

// File: tb/sim_xlat_buffer.sv
`timescale 1ns/1ps

module xb_ref #(
  parameter int ENTRIES = 10,
  parameter int WAYS    = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_fire,
  input logic [31:0] lk_addr,
  input logic [31:0] lk_stamp,
  input logic        wr_fire,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_stamp,
  input logic [15:0] wr_data
);
  localparam int SETS = ENTRIES / WAYS;
  bit          mv [ENTRIES];
  int unsigned mt [ENTRIES];
  int unsigned ms [ENTRIES];
  int unsigned md [ENTRIES];
  bit          e_valid, e_hit, e_rej;
  int unsigned e_data;

  always @(posedge clk) begin
    int unsigned vpn, st, tg, best;
    int pick;
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin mv[i] = 0; mt[i] = 0; ms[i] = 0; md[i] = 0; end
      e_valid = 0; e_hit = 0; e_rej = 0; e_data = 32'hFFFF_FFFF;
    end else begin
      e_rej = 0;
      if (wr_fire) begin
        vpn = wr_addr >> 16; st = vpn % SETS; tg = vpn / SETS; pick = -1;
        for (int w = 0; w < WAYS; w++)
          if (pick < 0 && mv[st*WAYS+w] && mt[st*WAYS+w] == tg) pick = w;
        for (int w = 0; w < WAYS; w++)
          if (pick < 0 && !mv[st*WAYS+w]) pick = w;
        if (pick < 0) begin
          best = 0;
          for (int w = 0; w < WAYS; w++)
            if (ms[st*WAYS+w] != 0 && (pick < 0 || ms[st*WAYS+w] < best)) begin
              pick = w; best = ms[st*WAYS+w];
            end
        end
        if (pick < 0) e_rej = 1;
        else begin
          mv[st*WAYS+pick] = 1; mt[st*WAYS+pick] = tg;
          ms[st*WAYS+pick] = wr_stamp; md[st*WAYS+pick] = wr_data;
        end
      end
      e_valid = lk_fire; e_hit = 0; e_data = 32'hFFFF_FFFF;
      if (lk_fire) begin
        vpn = lk_addr >> 16; st = vpn % SETS; tg = vpn / SETS;
        for (int w = 0; w < WAYS; w++)
          if (!e_hit && mv[st*WAYS+w] && mt[st*WAYS+w] == tg) begin
            e_hit = 1; e_data = md[st*WAYS+w]; ms[st*WAYS+w] = lk_stamp;
          end
      end
    end
  end
endmodule

module sim_xlat_buffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic lk_valid = 0, wr_valid = 0;
  logic [31:0] lk_addr = 0, wr_addr = 0, lk_stamp = 0, wr_stamp = 0;
  logic [15:0] wr_data = 0;
  logic [3:0] idx0 = 0;
  logic [8:0] idx1 = 0;

  logic lr0, wrr0, rv0, rh0, rj0, dv0;
  logic [31:0] rd0, ds0;
  logic [15:0] dt0, dd0;
  logic lr1, wrr1, rv1, rh1, rj1, dv1;
  logic [31:0] rd1, ds1;
  logic [15:0] dt1, dd1;

  xlat_buffer #(.ENTRIES(10), .WAYS(10), .DATA_W(16), .STAMP_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lr0), .lk_addr(lk_addr),
    .lk_stamp(lk_stamp), .rsp_valid(rv0), .rsp_hit(rh0), .rsp_data(rd0),
    .wr_valid(wr_valid), .wr_ready(wrr0), .wr_addr(wr_addr), .wr_stamp(wr_stamp),
    .wr_data(wr_data), .wr_reject(rj0), .dbg_idx(idx0), .dbg_valid(dv0),
    .dbg_tag(dt0), .dbg_stamp(ds0), .dbg_data(dd0));

  xlat_buffer #(.ENTRIES(512), .WAYS(4), .DATA_W(16), .STAMP_W(32)) u1 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lr1), .lk_addr(lk_addr),
    .lk_stamp(lk_stamp), .rsp_valid(rv1), .rsp_hit(rh1), .rsp_data(rd1),
    .wr_valid(wr_valid), .wr_ready(wrr1), .wr_addr(wr_addr), .wr_stamp(wr_stamp),
    .wr_data(wr_data), .wr_reject(rj1), .dbg_idx(idx1), .dbg_valid(dv1),
    .dbg_tag(dt1), .dbg_stamp(ds1), .dbg_data(dd1));

  xb_ref #(.ENTRIES(10), .WAYS(10)) m0 (
    .clk(clk), .rst_n(rst_n), .lk_fire(lk_valid && lr0), .lk_addr(lk_addr),
    .lk_stamp(lk_stamp), .wr_fire(wr_valid && wrr0), .wr_addr(wr_addr),
    .wr_stamp(wr_stamp), .wr_data(wr_data));
  xb_ref #(.ENTRIES(512), .WAYS(4)) m1 (
    .clk(clk), .rst_n(rst_n), .lk_fire(lk_valid && lr1), .lk_addr(lk_addr),
    .lk_stamp(lk_stamp), .wr_fire(wr_valid && wrr1), .wr_addr(wr_addr),
    .wr_stamp(wr_stamp), .wr_data(wr_data));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    int i0, i1;
    chk(rv0 == m0.e_valid, "R11 u0 rsp_valid", rv0, m0.e_valid);
    chk(rh0 == m0.e_hit, "R3 R9 u0 rsp_hit", rh0, m0.e_hit);
    chk(rd0 == m0.e_data, "R3 R4 R9 u0 rsp_data", rd0, m0.e_data);
    chk(rj0 == m0.e_rej, "R8 u0 wr_reject", rj0, m0.e_rej);
    chk(rv1 == m1.e_valid, "R11 u1 rsp_valid", rv1, m1.e_valid);
    chk(rh1 == m1.e_hit, "R2 R3 R9 u1 rsp_hit", rh1, m1.e_hit);
    chk(rd1 == m1.e_data, "R2 R4 R9 u1 rsp_data", rd1, m1.e_data);
    chk(rj1 == m1.e_rej, "R8 u1 wr_reject", rj1, m1.e_rej);
    i0 = int'(idx0); i1 = int'(idx1);
    chk(dv0 == m0.mv[i0], "R1 R6 R10 u0 dbg_valid", dv0, m0.mv[i0]);
    chk(dv1 == m1.mv[i1], "R1 R6 R10 u1 dbg_valid", dv1, m1.mv[i1]);
    if (m0.mv[i0]) begin
      chk(dt0 == 16'(m0.mt[i0]), "R2 R10 u0 dbg_tag", dt0, m0.mt[i0]);
      chk(ds0 == m0.ms[i0], "R5 R7 R8 u0 dbg_stamp", ds0, m0.ms[i0]);
      chk(dd0 == 16'(m0.md[i0]), "R5 R7 u0 dbg_data", dd0, m0.md[i0]);
    end
    if (m1.mv[i1]) begin
      chk(dt1 == 16'(m1.mt[i1]), "R2 R10 u1 dbg_tag", dt1, m1.mt[i1]);
      chk(ds1 == m1.ms[i1], "R5 R7 R8 u1 dbg_stamp", ds1, m1.ms[i1]);
      chk(dd1 == 16'(m1.md[i1]), "R5 R7 u1 dbg_data", dd1, m1.md[i1]);
    end
  endtask

  function automatic logic [31:0] pick_addr();
    int unsigned vpn;
    vpn = ($urandom % 8) * 128 + ($urandom % 2);
    return {vpn[15:0], 16'($urandom)};
  endfunction

  function automatic logic [31:0] pick_stamp(input int c);
    int unsigned r;
    r = $urandom % 12;
    if (r == 0) return 32'd0;
    if (r < 4) return 32'd5;
    return 32'(c);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset quiet state
    chk(rv0 == 0 && rj0 == 0, "R1 u0 quiet in reset", {rv0, rj0}, 0);
    chk(lr0 == 0 && wrr0 == 0, "R1 u0 ready low in reset", {lr0, wrr0}, 0);
    chk(rv1 == 0 && lr1 == 0, "R1 u1 quiet in reset", {rv1, lr1}, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: all entries invalid after reset
    for (int i = 0; i < 10; i++) begin
      idx0 = 4'(i); idx1 = 9'(i); #1;
      chk(dv0 == 0, "R1 u0 entry invalid", dv0, 0);
      chk(dv1 == 0, "R1 u1 entry invalid", dv1, 0);
    end
    chk(lr0 == 1 && wrr1 == 1, "R11 ready after reset", {lr0, wrr1}, 2'b11);
    for (int k = 0; k < 6000 && !done; k++) begin
      @(negedge clk);
      compare_all();
      lk_valid = ($urandom % 10) < 6;
      wr_valid = ($urandom % 10) < 5;
      lk_addr  = pick_addr();
      wr_addr  = pick_addr();
      lk_stamp = pick_stamp(k + 1);
      wr_stamp = pick_stamp(k + 1);
      wr_data  = 16'($urandom);
      idx0 = 4'(k % 10);
      idx1 = 9'(k % 16);
    end
    lk_valid = 0; wr_valid = 0;
    @(negedge clk);
    compare_all();
    @(negedge clk);
    compare_all();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule